// File: doc/BRIEF.md
# SMBus block transfer byte sequencer

This block expands a single block-transfer request into the ordered list of byte-level operations that a separate I2C byte engine carries out. The available operations are start with write direction, start with read direction, send one byte, receive one byte, NACK and stop. The sequencer issues one operation at a time. It then waits for the engine to report completion, the acknowledge result of a start, and any received byte. Bus timing on the wires belongs to the engine and is not handled here.

A request carries a 7-bit target address, a command byte, two data bytes and a protocol kind. It also carries a flag that puts the host in raw I2C form, in which the block protocols neither put a length byte on the wire nor expect one. A local 32-entry byte buffer holds the payload. The host fills the buffer before a write and reads it back after a read. The sequencer fills it with received bytes and takes bytes to send from it. When a request finishes, the block pulses a done strobe together with a byte count or a failure flag.

Top module: `smb_block_seq`

## Requirements
- R1: After reset, req_ready_o is 1, done_o is 0 and op_req_o is 0.
- R2: Operation codes on op_code_o are 0 start-write, 1 start-read, 2 send, 3 receive, 4 NACK and 5 stop. A start carries the target address on op_addr_o, and a send carries its byte on op_byte_o. For a read with a command phase, the order is start-write, then send of the command byte, then start-read.
- R3: For a read with no command phase, the first operation issued is start-read.
- R4: If a start-write is not acknowledged (op_ack_i = 0), the request fails at once. No further operation is issued, done_o comes with fail_o = 1, and count_o is 0.
- R5: If a start-read is not acknowledged after a command was sent, a stop is issued and then failure is reported. If no command was sent, failure is reported with no stop.
- R6: When the length is on the wire, the first received byte is the count. Otherwise the count is the requested length.
- R7: A received count above 32 gives zero data receives. NACK and stop still follow, and the request completes without failure with count_o = 0.
- R8: A read issues its data receives, then NACK, then stop, then pulses done_o for one cycle with the count. Data byte k is stored at buffer entry k.
- R9: A write issues start-write, the command send, a length send only when the length is on the wire, one send per data byte taken from buffer entries 0 upward, and then stop. Its count is the data length.
- R10: The encoding of req_kind_i is as follows. Kind 0 is block read, with command and length byte unless raw is set; in raw form the length is 32. Kind 1 is block write, length min(data0, 32), with length byte unless raw is set. Kind 2 is I2C block read, which always sends the command taken from data1, has no length byte, and uses length min(data0, 32). Kind 3 fails at once with no operation.
- R11: op_req_o is a one-cycle pulse. No new operation is issued until op_done_i has answered the previous one.
- R12: A request is taken only while req_ready_o is 1. While busy, req_valid_i and host buffer writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_ready_o | output | 1 | Idle, request can be taken |
| req_kind_i | input | 2 | Protocol kind |
| req_raw_i | input | 1 | Raw I2C form, no length byte |
| req_addr_i | input | 7 | Target address |
| req_cmd_i | input | 8 | Command byte |
| req_data0_i | input | 8 | Length for write and I2C block read |
| req_data1_i | input | 8 | Command for I2C block read |
| done_o | output | 1 | Completion pulse |
| fail_o | output | 1 | Failure, valid with done_o |
| count_o | output | 6 | Byte count, valid with done_o |
| op_req_o | output | 1 | Operation issue pulse |
| op_code_o | output | 3 | Operation code |
| op_addr_o | output | 7 | Address for starts |
| op_byte_o | output | 8 | Byte for sends |
| op_done_i | input | 1 | Engine finished the operation |
| op_ack_i | input | 1 | Start acknowledged |
| op_rdata_i | input | 8 | Received byte |
| buf_we_i | input | 1 | Host buffer write |
| buf_waddr_i | input | 5 | Host buffer write index |
| buf_wdata_i | input | 8 | Host buffer write data |
| buf_raddr_i | input | 5 | Host buffer read index |
| buf_rdata_o | output | 8 | Host buffer read data |

## Verification
The bench targets three boundaries. The first is a received count of exactly 32 against 33 and above. A design that truncates instead of collapsing would return 32 bytes where zero are due. The second is I2C block read lengths above 32, where a missing clamp overruns the buffer. The third is zero-length writes, where an off-by-one index would emit a stray send. It also checks which failures need a stop. A design that always stops, or never stops, after a missed start-read diverges in the operation log. Host writes and request strobes made mid-transfer must leave the send data and the operation order untouched.

// File: rtl/smb_seq_pkg.sv
package smb_seq_pkg;

  typedef enum logic [2:0] {
    OP_START_WR = 3'd0,
    OP_START_RD = 3'd1,
    OP_SEND     = 3'd2,
    OP_RECV     = 3'd3,
    OP_NACK     = 3'd4,
    OP_STOP     = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    KIND_BLK_RD = 2'd0,
    KIND_BLK_WR = 2'd1,
    KIND_I2C_RD = 2'd2,
    KIND_RSVD   = 2'd3
  } kind_e;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_START_W,
    PH_CMD,
    PH_START_R,
    PH_LEN_RX,
    PH_DATA_RX,
    PH_NACK,
    PH_STOP,
    PH_LEN_TX,
    PH_DATA_TX
  } phase_e;

  typedef struct packed {
    logic       legal;
    logic       write;
    logic       send_cmd;
    logic       len_byte;
    logic [7:0] cmd;
    logic [7:0] len;
  } req_t;

endpackage

// File: rtl/smb_req_decode.sv
module smb_req_decode
  import smb_seq_pkg::*;
#(
  parameter int MAX_LEN = 32
) (
  input  logic [1:0] kind_i,
  input  logic       raw_i,
  input  logic [7:0] cmd_i,
  input  logic [7:0] data0_i,
  input  logic [7:0] data1_i,
  output req_t       req_o
);

  localparam logic [7:0] MAX_B = 8'(MAX_LEN);

  logic [7:0] clamp_len;
  assign clamp_len = (data0_i > MAX_B) ? MAX_B : data0_i;

  always_comb begin
    req_o = '0;
    unique case (kind_e'(kind_i))
      KIND_BLK_RD: begin
        req_o.legal    = 1'b1;
        req_o.send_cmd = !raw_i;
        req_o.len_byte = !raw_i;
        req_o.cmd      = cmd_i;
        req_o.len      = MAX_B;
      end
      KIND_BLK_WR: begin
        req_o.legal    = 1'b1;
        req_o.write    = 1'b1;
        req_o.send_cmd = 1'b1;
        req_o.len_byte = !raw_i;
        req_o.cmd      = cmd_i;
        req_o.len      = clamp_len;
      end
      KIND_I2C_RD: begin
        req_o.legal    = 1'b1;
        req_o.send_cmd = 1'b1;
        req_o.cmd      = data1_i;
        req_o.len      = clamp_len;
      end
      default: req_o = '0;
    endcase
  end

endmodule

// File: rtl/smb_byte_buf.sv
module smb_byte_buf #(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [7:0]    rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [7:0]    rdata_b_o
);

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];

endmodule

// File: rtl/smb_seq_fsm.sv
module smb_seq_fsm
  import smb_seq_pkg::*;
#(
  parameter int MAX_LEN = 32,
  parameter int AW      = $clog2(MAX_LEN),
  parameter int CW      = $clog2(MAX_LEN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  req_t          req_i,
  input  logic [6:0]    addr_i,
  output logic          idle_o,
  output logic          done_o,
  output logic          fail_o,
  output logic [CW-1:0] count_o,
  output logic          op_req_o,
  output logic [2:0]    op_code_o,
  output logic [6:0]    op_addr_o,
  output logic [7:0]    op_byte_o,
  input  logic          op_done_i,
  input  logic          op_ack_i,
  input  logic [7:0]    op_rdata_i,
  output logic          buf_we_o,
  output logic [AW-1:0] buf_addr_o,
  output logic [7:0]    buf_wdata_o,
  input  logic [7:0]    buf_rdata_i
);

  localparam logic [CW-1:0] ONE   = CW'(1);
  localparam logic [7:0]    MAX_B = 8'(MAX_LEN);

  phase_e        phase_q, nxt;
  logic          wait_q, write_q, send_cmd_q, len_byte_q, fail_pend_q;
  logic [7:0]    cmd_q;
  logic [6:0]    addr_q;
  logic [CW-1:0] cnt_q, idx_q, cnt_ld;
  logic          done_q, done_fail_q;
  logic [CW-1:0] done_cnt_q;
  logic          fin, fin_fail, set_fail_pend, load_cnt, idx_inc, last_idx;
  logic          step;

  assign step     = wait_q && op_done_i;
  assign last_idx = (idx_q + ONE) == cnt_q;

  always_comb begin
    nxt           = phase_q;
    fin           = 1'b0;
    fin_fail      = 1'b0;
    set_fail_pend = 1'b0;
    load_cnt      = 1'b0;
    cnt_ld        = '0;
    idx_inc       = 1'b0;
    unique case (phase_q)
      PH_START_W: begin
        if (!op_ack_i) begin
          fin      = 1'b1;
          fin_fail = 1'b1;
        end else begin
          nxt = PH_CMD;
        end
      end
      PH_CMD: begin
        if (!write_q)        nxt = PH_START_R;
        else if (len_byte_q) nxt = PH_LEN_TX;
        else                 nxt = (cnt_q == '0) ? PH_STOP : PH_DATA_TX;
      end
      PH_START_R: begin
        if (!op_ack_i) begin
          // a command phase left the bus claimed: release it first
          if (send_cmd_q) begin
            nxt           = PH_STOP;
            set_fail_pend = 1'b1;
          end else begin
            fin      = 1'b1;
            fin_fail = 1'b1;
          end
        end else if (len_byte_q) begin
          nxt = PH_LEN_RX;
        end else begin
          nxt = (cnt_q == '0) ? PH_NACK : PH_DATA_RX;
        end
      end
      PH_LEN_RX: begin
        load_cnt = 1'b1;
        // an oversize count collapses to zero, it is not truncated
        cnt_ld   = (op_rdata_i > MAX_B) ? '0 : op_rdata_i[CW-1:0];
        nxt      = (cnt_ld == '0) ? PH_NACK : PH_DATA_RX;
      end
      PH_DATA_RX: begin
        idx_inc = 1'b1;
        nxt     = last_idx ? PH_NACK : PH_DATA_RX;
      end
      PH_NACK: nxt = PH_STOP;
      PH_STOP: begin
        fin      = 1'b1;
        fin_fail = fail_pend_q;
      end
      PH_LEN_TX: nxt = (cnt_q == '0) ? PH_STOP : PH_DATA_TX;
      PH_DATA_TX: begin
        idx_inc = 1'b1;
        nxt     = last_idx ? PH_STOP : PH_DATA_TX;
      end
      default: nxt = PH_IDLE;
    endcase
    if (fin) nxt = PH_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_IDLE;
      wait_q      <= 1'b0;
      write_q     <= 1'b0;
      send_cmd_q  <= 1'b0;
      len_byte_q  <= 1'b0;
      fail_pend_q <= 1'b0;
      cmd_q       <= '0;
      addr_q      <= '0;
      cnt_q       <= '0;
      idx_q       <= '0;
      done_q      <= 1'b0;
      done_fail_q <= 1'b0;
      done_cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (phase_q == PH_IDLE) begin
        if (req_valid_i) begin
          if (!req_i.legal) begin
            done_q      <= 1'b1;
            done_fail_q <= 1'b1;
            done_cnt_q  <= '0;
          end else begin
            write_q     <= req_i.write;
            send_cmd_q  <= req_i.send_cmd;
            len_byte_q  <= req_i.len_byte;
            cmd_q       <= req_i.cmd;
            addr_q      <= addr_i;
            cnt_q       <= req_i.len[CW-1:0];
            idx_q       <= '0;
            fail_pend_q <= 1'b0;
            wait_q      <= 1'b0;
            phase_q     <= (req_i.write || req_i.send_cmd) ? PH_START_W : PH_START_R;
          end
        end
      end else if (!wait_q) begin
        wait_q <= 1'b1;
      end else if (op_done_i) begin
        wait_q  <= 1'b0;
        phase_q <= nxt;
        if (set_fail_pend) fail_pend_q <= 1'b1;
        if (load_cnt)      cnt_q       <= cnt_ld;
        if (idx_inc)       idx_q       <= idx_q + ONE;
        if (fin) begin
          done_q      <= 1'b1;
          done_fail_q <= fin_fail;
          done_cnt_q  <= fin_fail ? '0 : cnt_q;
        end
      end
    end
  end

  always_comb begin
    op_code_o = OP_STOP;
    op_byte_o = '0;
    unique case (phase_q)
      PH_START_W: op_code_o = OP_START_WR;
      PH_START_R: op_code_o = OP_START_RD;
      PH_CMD: begin
        op_code_o = OP_SEND;
        op_byte_o = cmd_q;
      end
      PH_LEN_TX: begin
        op_code_o = OP_SEND;
        op_byte_o = 8'(cnt_q);
      end
      PH_DATA_TX: begin
        op_code_o = OP_SEND;
        op_byte_o = buf_rdata_i;
      end
      PH_LEN_RX, PH_DATA_RX: op_code_o = OP_RECV;
      PH_NACK:               op_code_o = OP_NACK;
      default:               op_code_o = OP_STOP;
    endcase
  end

  assign idle_o      = (phase_q == PH_IDLE);
  assign op_req_o    = !idle_o && !wait_q;
  assign op_addr_o   = addr_q;
  assign buf_addr_o  = idx_q[AW-1:0];
  assign buf_we_o    = step && (phase_q == PH_DATA_RX);
  assign buf_wdata_o = op_rdata_i;
  assign done_o      = done_q;
  assign fail_o      = done_fail_q;
  assign count_o     = done_cnt_q;

endmodule

// File: rtl/smb_block_seq.sv
module smb_block_seq
  import smb_seq_pkg::*;
#(
  parameter int MAX_LEN = 32,
  localparam int AW     = $clog2(MAX_LEN),
  localparam int CW     = $clog2(MAX_LEN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [1:0]    req_kind_i,
  input  logic          req_raw_i,
  input  logic [6:0]    req_addr_i,
  input  logic [7:0]    req_cmd_i,
  input  logic [7:0]    req_data0_i,
  input  logic [7:0]    req_data1_i,
  output logic          done_o,
  output logic          fail_o,
  output logic [CW-1:0] count_o,
  output logic          op_req_o,
  output logic [2:0]    op_code_o,
  output logic [6:0]    op_addr_o,
  output logic [7:0]    op_byte_o,
  input  logic          op_done_i,
  input  logic          op_ack_i,
  input  logic [7:0]    op_rdata_i,
  input  logic          buf_we_i,
  input  logic [AW-1:0] buf_waddr_i,
  input  logic [7:0]    buf_wdata_i,
  input  logic [AW-1:0] buf_raddr_i,
  output logic [7:0]    buf_rdata_o
);

  req_t          dec_req;
  logic          idle;
  logic          seq_we;
  logic [AW-1:0] seq_addr;
  logic [7:0]    seq_wdata, seq_rdata;
  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [7:0]    mem_wdata;

  smb_req_decode #(.MAX_LEN(MAX_LEN)) u_dec (
    .kind_i  (req_kind_i),
    .raw_i   (req_raw_i),
    .cmd_i   (req_cmd_i),
    .data0_i (req_data0_i),
    .data1_i (req_data1_i),
    .req_o   (dec_req)
  );

  smb_seq_fsm #(.MAX_LEN(MAX_LEN), .AW(AW), .CW(CW)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_i       (dec_req),
    .addr_i      (req_addr_i),
    .idle_o      (idle),
    .done_o      (done_o),
    .fail_o      (fail_o),
    .count_o     (count_o),
    .op_req_o    (op_req_o),
    .op_code_o   (op_code_o),
    .op_addr_o   (op_addr_o),
    .op_byte_o   (op_byte_o),
    .op_done_i   (op_done_i),
    .op_ack_i    (op_ack_i),
    .op_rdata_i  (op_rdata_i),
    .buf_we_o    (seq_we),
    .buf_addr_o  (seq_addr),
    .buf_wdata_o (seq_wdata),
    .buf_rdata_i (seq_rdata)
  );

  // host owns the buffer only while idle
  assign mem_we    = seq_we || (buf_we_i && idle);
  assign mem_waddr = seq_we ? seq_addr  : buf_waddr_i;
  assign mem_wdata = seq_we ? seq_wdata : buf_wdata_i;

  smb_byte_buf #(.DEPTH(MAX_LEN), .AW(AW)) u_buf (
    .clk_i     (clk_i),
    .we_i      (mem_we),
    .waddr_i   (mem_waddr),
    .wdata_i   (mem_wdata),
    .raddr_a_i (buf_raddr_i),
    .rdata_a_o (buf_rdata_o),
    .raddr_b_i (seq_addr),
    .rdata_b_o (seq_rdata)
  );

  assign req_ready_o = idle;

endmodule

// File: rtl/smb_block_seq_chk.sv
module smb_block_seq_chk #(
  parameter int MAX_LEN = 32,
  localparam int CW     = $clog2(MAX_LEN + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_ready_o,
  input logic          done_o,
  input logic          fail_o,
  input logic [CW-1:0] count_o,
  input logic          op_req_o,
  input logic [2:0]    op_code_o,
  input logic          op_done_i
);

  logic outstanding_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        outstanding_q <= 1'b0;
    else if (op_req_o)  outstanding_q <= 1'b1;
    else if (op_done_i) outstanding_q <= 1'b0;
  end

  a_r11_pulse_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_req_o |=> !op_req_o);

  a_r11_one_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_req_o |-> !outstanding_q);

  a_r12_idle_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !op_req_o);

  a_r2_code_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_req_o |-> (op_code_o <= 3'd5));

  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r4_fail_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fail_o) |-> (count_o == '0));

  a_r7_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (count_o <= CW'(MAX_LEN)));

endmodule

bind smb_block_seq smb_block_seq_chk #(.MAX_LEN(MAX_LEN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .done_o      (done_o),
  .fail_o      (fail_o),
  .count_o     (count_o),
  .op_req_o    (op_req_o),
  .op_code_o   (op_code_o),
  .op_done_i   (op_done_i)
);

// File: tb/smb_block_seq_bench.sv
module smb_block_seq_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_kind = '0;
  logic       req_raw = 1'b0;
  logic [6:0] req_addr = '0;
  logic [7:0] req_cmd = '0, req_d0 = '0, req_d1 = '0;
  logic       done, fail;
  logic [5:0] count;
  logic       op_req;
  logic [2:0] op_code;
  logic [6:0] op_addr;
  logic [7:0] op_byte;
  logic       op_done = 1'b0, op_ack = 1'b0;
  logic [7:0] op_rdata = '0;
  logic       buf_we = 1'b0;
  logic [4:0] buf_waddr = '0, buf_raddr = '0;
  logic [7:0] buf_wdata = '0;
  logic [7:0] buf_rdata;

  always #5 clk = ~clk;

  smb_block_seq u_smb_block_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_kind_i(req_kind), .req_raw_i(req_raw), .req_addr_i(req_addr),
    .req_cmd_i(req_cmd), .req_data0_i(req_d0), .req_data1_i(req_d1),
    .done_o(done), .fail_o(fail), .count_o(count),
    .op_req_o(op_req), .op_code_o(op_code), .op_addr_o(op_addr), .op_byte_o(op_byte),
    .op_done_i(op_done), .op_ack_i(op_ack), .op_rdata_i(op_rdata),
    .buf_we_i(buf_we), .buf_waddr_i(buf_waddr), .buf_wdata_i(buf_wdata),
    .buf_raddr_i(buf_raddr), .buf_rdata_o(buf_rdata)
  );

  int checks = 0, fails = 0;

  // engine model state
  bit         ack_w = 1'b1, ack_r = 1'b1;
  logic [7:0] rx_q [64];
  int         rx_k = 0;
  int         nlog = 0;
  logic [2:0] log_code [128];
  logic [7:0] log_byte [128];

  // expectation state
  logic [7:0] shadow [32];
  int         nexp;
  logic [2:0] exp_code [128];
  logic [7:0] exp_byte [128];
  bit         e_fail, e_read;
  int         e_cnt, e_off;
  bit         poke = 1'b0;

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  initial begin
    forever begin
      if (op_req !== 1'b1) @(negedge clk);
      else begin
        if (nlog < 128) begin
          log_code[nlog] = op_code;
          log_byte[nlog] = (op_code <= 3'd1) ? {1'b0, op_addr} : op_byte;
        end
        nlog++;
        op_ack   = (op_code == 3'd0) ? ack_w : (op_code == 3'd1) ? ack_r : 1'b1;
        op_rdata = (op_code == 3'd3) ? rx_q[rx_k % 64] : 8'h00;
        if (op_code == 3'd3) rx_k++;
        repeat (2) @(negedge clk);
        op_done = 1'b1;
        @(negedge clk);
        op_done = 1'b0;
      end
    end
  end

  task automatic push(logic [2:0] c, logic [7:0] b);
    exp_code[nexp] = c;
    exp_byte[nexp] = b;
    nexp++;
  endtask

  task automatic build_exp();
    bit sc, lb;
    logic [7:0] cm;
    int ln, n;
    nexp = 0; e_fail = 1'b0; e_cnt = 0; e_off = 0; e_read = 1'b0;
    sc = 1'b0; lb = 1'b0; cm = req_cmd;
    ln = (req_d0 > 8'd32) ? 32 : int'(req_d0);
    case (req_kind)
      2'd0: begin sc = !req_raw; lb = !req_raw; ln = 32; e_read = 1'b1; end
      2'd1: begin lb = !req_raw; end
      2'd2: begin sc = 1'b1; cm = req_d1; e_read = 1'b1; end
      default: begin e_fail = 1'b1; return; end
    endcase
    if (e_read) begin
      if (sc) begin
        push(3'd0, {1'b0, req_addr});
        if (!ack_w) begin e_fail = 1'b1; return; end
        push(3'd2, cm);
      end
      push(3'd1, {1'b0, req_addr});
      if (!ack_r) begin
        if (sc) push(3'd5, 8'h00);
        e_fail = 1'b1;
        return;
      end
      if (lb) begin
        push(3'd3, 8'h00);
        n = (rx_q[0] > 8'd32) ? 0 : int'(rx_q[0]);
        e_off = 1;
      end else n = ln;
      for (int i = 0; i < n; i++) push(3'd3, 8'h00);
      push(3'd4, 8'h00);
      push(3'd5, 8'h00);
      e_cnt = n;
    end else begin
      push(3'd0, {1'b0, req_addr});
      if (!ack_w) begin e_fail = 1'b1; return; end
      push(3'd2, cm);
      if (lb) push(3'd2, 8'(ln));
      for (int i = 0; i < ln; i++) push(3'd2, shadow[i]);
      push(3'd5, 8'h00);
      e_cnt = ln;
    end
  endtask

  task automatic host_wr(int idx, logic [7:0] v);
    @(negedge clk);
    buf_we = 1'b1; buf_waddr = 5'(idx); buf_wdata = v;
    @(negedge clk);
    buf_we = 1'b0;
    shadow[idx] = v;
  endtask

  task automatic run(string rq);
    int  wd;
    bit  got, mism;
    int  at;
    build_exp();
    nlog = 0; rx_k = 0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R12 ready before request", int'(req_ready), 1);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      repeat (2) @(negedge clk);
      req_valid = 1'b1; req_kind = 2'd3;
      buf_we = 1'b1; buf_waddr = 5'd0; buf_wdata = ~shadow[0];
      @(negedge clk);
      req_valid = 1'b0; buf_we = 1'b0;
    end
    got = 1'b0; wd = 0;
    while (!got && wd < 3000) begin
      if (done === 1'b1) got = 1'b1;
      else begin @(negedge clk); wd++; end
    end
    chk(got, "R11 done reached (watchdog)", int'(got), 1);
    if (!got) return;
    chk(fail == e_fail, {rq, " fail flag"}, int'(fail), int'(e_fail));
    chk(int'(count) == e_cnt, {rq, " count"}, int'(count), e_cnt);
    mism = (nlog != nexp); at = -1;
    for (int i = 0; i < nexp && i < nlog && at < 0; i++) begin
      if (log_code[i] != exp_code[i] ||
          (exp_code[i] <= 3'd2 && log_byte[i] != exp_byte[i])) begin
        mism = 1'b1; at = i;
      end
    end
    chk(!mism, {rq, " op sequence (len / first bad index)"},
        (at < 0) ? nlog : at, (at < 0) ? nexp : int'(exp_code[at]));
    if (e_read && !e_fail) begin
      mism = 1'b0; at = 0;
      for (int i = 0; i < e_cnt; i++) begin
        buf_raddr = 5'(i);
        #1;
        if (buf_rdata != rx_q[i + e_off] && !mism) begin mism = 1'b1; at = i; end
        shadow[i] = rx_q[i + e_off];
      end
      chk(!mism, "R8 received bytes in buffer", at, int'(rx_q[at + e_off]));
    end
    @(negedge clk);
  endtask

  task automatic set_req(logic [1:0] k, bit r, logic [7:0] d0, logic [7:0] d1);
    req_kind = k; req_raw = r; req_d0 = d0; req_d1 = d1;
    req_addr = 7'($urandom); req_cmd = 8'($urandom);
  endtask

  task automatic fill_rx(logic [7:0] first);
    for (int i = 0; i < 64; i++) rx_q[i] = 8'($urandom);
    rx_q[0] = first;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 32; i++) shadow[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    chk(done == 1'b0, "R1 done low after reset", int'(done), 0);
    chk(op_req == 1'b0, "R1 no op after reset", int'(op_req), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 32; i++) host_wr(i, 8'($urandom));

    // R2 R6 R8: SMBus read, length byte 5
    fill_rx(8'd5); set_req(2'd0, 1'b0, 8'd0, 8'd0); run("R2 R6 R8");
    // R7: count exactly at max, then just above
    fill_rx(8'd32); set_req(2'd0, 1'b0, 8'd0, 8'd0); run("R7 count at max");
    fill_rx(8'd33); set_req(2'd0, 1'b0, 8'd0, 8'd0); run("R7 count above max");
    fill_rx(8'd0);  set_req(2'd0, 1'b0, 8'd0, 8'd0); run("R6 zero count");
    // R3: raw read, no command, 32 bytes
    fill_rx(8'd9);  set_req(2'd0, 1'b1, 8'd0, 8'd0); run("R3 raw read");
    // R10: I2C block read clamp and command from data1
    fill_rx(8'd1);  set_req(2'd2, 1'b0, 8'd50, 8'hA5); run("R10 i2c read clamp");
    fill_rx(8'd1);  set_req(2'd2, 1'b1, 8'd3, 8'h3C); run("R10 i2c read short");
    // R9: writes with and without length byte, and empty
    set_req(2'd1, 1'b0, 8'd4, 8'd0); run("R9 write with length");
    set_req(2'd1, 1'b1, 8'd6, 8'd0); run("R9 raw write");
    set_req(2'd1, 1'b0, 8'd0, 8'd0); run("R9 empty write");
    set_req(2'd1, 1'b1, 8'd40, 8'd0); run("R10 write clamp");
    // R4 / R5 start failures
    ack_w = 1'b0; set_req(2'd0, 1'b0, 8'd0, 8'd0); run("R4 read start-write nack");
    set_req(2'd1, 1'b0, 8'd3, 8'd0); run("R4 write start-write nack");
    ack_w = 1'b1; ack_r = 1'b0;
    set_req(2'd2, 1'b0, 8'd4, 8'd1); run("R5 start-read nack after command");
    set_req(2'd0, 1'b1, 8'd0, 8'd0); run("R5 start-read nack raw");
    ack_r = 1'b1;
    set_req(2'd3, 1'b0, 8'd0, 8'd0); run("R10 reserved kind");
    // R12: strobe and host write while busy
    poke = 1'b1; set_req(2'd1, 1'b1, 8'd2, 8'd0); run("R12 busy write");
    poke = 1'b0;
    buf_raddr = 5'd0; #1;
    chk(buf_rdata == shadow[0], "R12 buffer untouched while busy", int'(buf_rdata), int'(shadow[0]));

    for (int it = 0; it < 60; it++) begin
      logic [1:0] k;
      k = ($urandom % 10 == 0) ? 2'd3 : 2'($urandom % 3);
      ack_w = ($urandom % 8) != 0;
      ack_r = ($urandom % 8) != 0;
      fill_rx(8'($urandom % 40));
      if (k == 2'd1) for (int i = 0; i < 32; i++) host_wr(i, 8'($urandom));
      set_req(k, 1'($urandom), 8'($urandom % 40), 8'($urandom));
      run("R10 random");
    end
    ack_w = 1'b1; ack_r = 1'b1;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    fails++;
    checks++;
    $display("FAIL R11: watchdog expired, actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule